// File: doc/BRIEF.md
# Decimating Systolic FIR Cell Array

This block is the arithmetic core of a programmable FIR filter. Eight multiply-accumulate cells receive the same 9-bit signed sample. A chain of 9-bit signed coefficients moves from one cell to the next. Every cell multiplies its sample register by its coefficient register on each clock and adds the 18-bit product into a private 26-bit accumulator. The accumulators are brought out in parallel to a separate readout stage, which also owns a per-cell clear line.

Between each pair of neighbouring cells the coefficient passes through zero to three extra delay registers, chosen by a 2-bit decimation select. A coefficient therefore moves one cell further every 1, 2, 3 or 4 shifting clocks. This lets the same array compute plain or 2:1 to 4:1 decimated filters.

The sample-enable, coefficient-enable, decimation-select and reset inputs each pass through one internal register before they act. A caller asserts each control one clock ahead of the word it qualifies. The coefficient leaving the last cell is brought out with a flag so that arrays can be chained.

Top module: `fir_cell_array`

## Requirements
- R1: If `data_en_n` was low in cycle t-1, every cell's sample register loads `din` at the edge ending cycle t. If it was high, the sample register loads zero, so later products are zero whatever `din` carries.
- R2: If `coef_en_n` was low in cycle t-1, the coefficient chain shifts at the edge ending cycle t: cell 0 loads `cin`, and each cell's delay registers and the next cell's coefficient register advance. Otherwise every coefficient and delay register holds its value.
- R3: With decimation select value d (0 to 3), a coefficient that enters cell 0 on shift 1 first appears on `cout` after shift 8*(d+1). `cout` is the last cell's coefficient delayed by d further shifts.
- R4: A new `dec_sel` value takes effect one clock after it is presented. It selects the tap used at the following shift and on `cout`.
- R5: If `rst_n` was low in cycle t-1, the edge ending cycle t clears all sample, coefficient, delay and control registers, so `cout` is 0 and `cout_valid` is 0 afterwards. Reset never changes an accumulator.
- R6: On each edge, every accumulator whose clear bit is low adds the sign-extended signed product of its cell's sample and coefficient registers.
- R7: `acc_clr[i]` high at an edge sets accumulator i to zero at that edge, overriding the add. This works even during reset.
- R8: `cout_valid` is high exactly in the cycles after an edge at which `coef_en_n` was low and no reset was pending. It marks that the chain shifts at the coming edge.
- R9: Accumulators wrap modulo 2^26. `acc_all[26*i +: 26]` carries cell i as a two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset request, registered before it acts |
| data_en_n | input | 1 | Active-low sample enable, one clock ahead of `din` |
| din | input | 9 | Signed sample broadcast to all cells |
| coef_en_n | input | 1 | Active-low coefficient shift enable, one clock ahead of `cin` |
| cin | input | 9 | Signed coefficient entering cell 0 |
| dec_sel | input | 2 | Number of delay registers between cells (0 to 3) |
| acc_clr | input | 8 | Per-cell accumulator clear from the readout stage |
| cout | output | 9 | Coefficient leaving the last cell, for cascading |
| cout_valid | output | 1 | Chain shifts at the coming edge |
| acc_all | output | 208 | All eight 26-bit accumulators, cell i at bits 26*i+25 down to 26*i |

## Verification
Two collisions are provoked on purpose. The first is a pending reset landing on the same edge as a coefficient shift. The bench keeps `coef_en_n` low with random coefficients while it pulls `rst_n` low, and the reset must win. The accumulators, which the sample register feeds, must come through unchanged. The second is an accumulator clear landing on an edge that also carries a nonzero product. Random clear bits during streaming cause this, and the cleared cell must read zero rather than zero plus the product. Both are judged on every clock against a behavioural model. That model keeps one coefficient history per cell instead of a register chain.

// File: rtl/fir_array_pkg.sv
package fir_array_pkg;

  localparam int DEF_CELLS  = 8;
  localparam int DEF_DATA_W = 9;
  localparam int DEF_COEF_W = 9;
  localparam int DEF_ACC_W  = 26;

  // decimation select: number of extra delay registers between cells
  typedef enum logic [1:0] {
    DEC_1TO1 = 2'd0,
    DEC_2TO1 = 2'd1,
    DEC_3TO1 = 2'd2,
    DEC_4TO1 = 2'd3
  } dec_mode_e;

  localparam int SEL_W     = $bits(dec_mode_e);
  localparam int MAX_DELAY = (1 << SEL_W) - 1;

  // registered copy of the control inputs
  typedef struct packed {
    logic      data_take;
    logic      coef_take;
    dec_mode_e dec;
  } ctrl_reg_t;

  function automatic int unsigned shift_period(input dec_mode_e m);
    return int'(m) + 1;
  endfunction

endpackage

// File: rtl/fir_ctrl_pipe.sv
module fir_ctrl_pipe
  import fir_array_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      data_en_n,
  input  logic      coef_en_n,
  input  logic [SEL_W-1:0] dec_sel,
  output logic      rst_pend,
  output logic      data_take,
  output logic      coef_take,
  output logic      shift_ev,
  output dec_mode_e dec_q
);

  ctrl_reg_t ctrl_q;

  always_ff @(posedge clk) begin
    rst_pend <= ~rst_n;
    if (rst_pend) begin
      ctrl_q <= '{data_take: 1'b0, coef_take: 1'b0, dec: DEC_1TO1};
    end else begin
      ctrl_q <= '{data_take: ~data_en_n,
                  coef_take: ~coef_en_n,
                  dec:       dec_mode_e'(dec_sel)};
    end
  end

  assign data_take = ctrl_q.data_take;
  assign coef_take = ctrl_q.coef_take;
  assign dec_q     = ctrl_q.dec;
  // the chain only moves when no reset is waiting at the same edge
  assign shift_ev  = ctrl_q.coef_take & ~rst_pend;

endmodule

// File: rtl/fir_coef_stage.sv
module fir_coef_stage #(
  parameter int COEF_W = 9,
  parameter int SEL_W  = 2,
  localparam int DEPTH = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic [SEL_W-1:0]  tap_sel,
  input  logic [COEF_W-1:0] coef_in,
  output logic [COEF_W-1:0] c_q,
  output logic [COEF_W-1:0] tap_out
);

  logic [COEF_W-1:0] taps [DEPTH+1];

  always_ff @(posedge clk) begin
    if (clear)      c_q <= '0;
    else if (shift) c_q <= coef_in;
  end

  assign taps[0] = c_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_delay
    logic [COEF_W-1:0] d_r;
    always_ff @(posedge clk) begin
      if (clear)      d_r <= '0;
      else if (shift) d_r <= taps[k];
    end
    assign taps[k+1] = d_r;
  end

  assign tap_out = taps[tap_sel];

  // R2: no shift event means the coefficient register keeps its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || clear)
    !shift |=> $stable(c_q));

endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int DATA_W = 9,
  parameter int COEF_W = 9,
  parameter int ACC_W  = 26,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] din,
  input  logic signed [COEF_W-1:0] coef,
  input  logic                     acc_clr,
  output logic signed [ACC_W-1:0]  acc_q
);

  logic signed [DATA_W-1:0] x_q;

  function automatic logic signed [PROD_W-1:0] mul_s(
    input logic signed [DATA_W-1:0] a,
    input logic signed [COEF_W-1:0] b);
    return PROD_W'(a) * PROD_W'(b);
  endfunction

  function automatic logic signed [ACC_W-1:0] mac_next(
    input logic signed [ACC_W-1:0]  acc,
    input logic signed [PROD_W-1:0] p);
    return acc + {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  always_ff @(posedge clk) begin
    if (clear)     x_q <= '0;
    else if (take) x_q <= din;
    else           x_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (acc_clr) acc_q <= '0;
    else         acc_q <= mac_next(acc_q, mul_s(x_q, coef));
  end

  // R7: a clear at an edge leaves a zero accumulator behind it
  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0));

  // R1: a gated sample one cycle back contributes nothing at the next edge
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(take) && !acc_clr) |=> $stable(acc_q));

endmodule

// File: rtl/fir_cell_array.sv
module fir_cell_array
  import fir_array_pkg::*;
#(
  parameter int N_CELLS = DEF_CELLS,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int COEF_W  = DEF_COEF_W,
  parameter int ACC_W   = DEF_ACC_W,
  localparam int ALL_W  = N_CELLS * ACC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_en_n,
  input  logic [DATA_W-1:0]  din,
  input  logic               coef_en_n,
  input  logic [COEF_W-1:0]  cin,
  input  logic [SEL_W-1:0]   dec_sel,
  input  logic [N_CELLS-1:0] acc_clr,
  output logic [COEF_W-1:0]  cout,
  output logic               cout_valid,
  output logic [ALL_W-1:0]   acc_all
);

  logic      rst_pend;
  logic      data_take;
  logic      coef_take;
  logic      shift_ev;
  dec_mode_e dec_q;

  logic [COEF_W-1:0] coef_link [N_CELLS+1];
  logic [COEF_W-1:0] c_vec     [N_CELLS];

  fir_ctrl_pipe u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_en_n (data_en_n),
    .coef_en_n (coef_en_n),
    .dec_sel   (dec_sel),
    .rst_pend  (rst_pend),
    .data_take (data_take),
    .coef_take (coef_take),
    .shift_ev  (shift_ev),
    .dec_q     (dec_q)
  );

  assign coef_link[0] = cin;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic signed [ACC_W-1:0] acc_w;

    fir_coef_stage #(
      .COEF_W (COEF_W),
      .SEL_W  (SEL_W)
    ) u_coef (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rst_pend),
      .shift   (shift_ev),
      .tap_sel (dec_q),
      .coef_in (coef_link[i]),
      .c_q     (c_vec[i]),
      .tap_out (coef_link[i+1])
    );

    fir_mac_cell #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rst_pend),
      .take    (data_take),
      .din     (din),
      .coef    (c_vec[i]),
      .acc_clr (acc_clr[i]),
      .acc_q   (acc_w)
    );

    assign acc_all[i*ACC_W +: ACC_W] = acc_w;
  end

  assign cout       = coef_link[N_CELLS];
  assign cout_valid = coef_take;

  // R3: with no decimation registers a coefficient moves one cell per shift
  for (genvar i = 0; i < N_CELLS - 1; i++) begin : g_pass_chk
    p_dec0_pass_r3: assert property (@(posedge clk) disable iff (!rst_n || rst_pend)
      (shift_ev && dec_q == DEC_1TO1) |=> (c_vec[i+1] == $past(c_vec[i])));
  end

  // R5: the final cycle of a reset request empties the cascade output
  p_reset_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend && rst_n) |=> (cout == '0 && !cout_valid));

  // R8: the valid flag follows the enable pin one clock later
  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_pend) |-> (cout_valid == !$past(coef_en_n)));

endmodule

// File: tb/tb_fir_cell_array.sv
module tb_fir_cell_array;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 26;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           data_en_n;
  logic [8:0]     din;
  logic           coef_en_n;
  logic [8:0]     cin;
  logic [1:0]     dec_sel;
  logic [N-1:0]   acc_clr;
  logic [8:0]     cout;
  logic           cout_valid;
  logic [N*AW-1:0] acc_all;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_cell_array dut (
    .clk (clk), .rst_n (rst_n), .data_en_n (data_en_n), .din (din),
    .coef_en_n (coef_en_n), .cin (cin), .dec_sel (dec_sel),
    .acc_clr (acc_clr), .cout (cout), .cout_valid (cout_valid),
    .acc_all (acc_all)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int sx9(input logic [8:0] v);
    return int'($signed(v));
  endfunction

  // behavioural reference: per-cell coefficient history, newest first
  int     hist [N][$];
  longint m_acc [N];
  int     m_x, m_dec;
  bit     m_de, m_ce, m_rst;

  initial begin
    for (int i = 0; i < N; i++) begin
      hist[i] = {0, 0, 0, 0};
      m_acc[i] = 0;
    end
    m_x = 0; m_dec = 0; m_de = 0; m_ce = 0; m_rst = 0;
  end

  always @(posedge clk) begin
    int newc [N];
    for (int i = 0; i < N; i++) begin
      if (acc_clr[i]) m_acc[i] = 0;
      else m_acc[i] = (m_acc[i] + longint'(m_x) * longint'(hist[i][0])) & AMASK;
    end
    if (m_rst) begin
      m_x = 0;
      for (int i = 0; i < N; i++) hist[i] = {0, 0, 0, 0};
      m_de = 0; m_ce = 0; m_dec = 0;
    end else begin
      if (m_ce) begin
        newc[0] = sx9(cin);
        for (int i = 1; i < N; i++) newc[i] = hist[i-1][m_dec];
        for (int i = 0; i < N; i++) begin
          hist[i].push_front(newc[i]);
          void'(hist[i].pop_back());
        end
      end
      m_x   = m_de ? sx9(din) : 0;
      m_de  = !data_en_n;
      m_ce  = !coef_en_n;
      m_dec = int'(dec_sel);
    end
    m_rst = !rst_n;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      for (int i = 0; i < N; i++)
        chk(acc_all[i*AW +: AW] == m_acc[i][AW-1:0], "R6 R7 R9 acc",
            longint'(acc_all[i*AW +: AW]), m_acc[i]);
      chk(cout == 9'(hist[N-1][m_dec]), "R3 R4 cout",
          longint'(cout), longint'(hist[N-1][m_dec] & 'h1FF));
      chk(cout_valid == m_ce, "R8 cout_valid", longint'(cout_valid), longint'(m_ce));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [8:0]      held;
    logic [N*AW-1:0] snap;
    rst_n = 0; data_en_n = 1; coef_en_n = 1; din = '0; cin = '0;
    dec_sel = '0; acc_clr = '1;
    repeat (4) tick();
    rst_n = 1;
    tick(); tick();
    cmp_en = 1;
    // R5 and R7: state right after reset and clear
    chk(cout == 0, "R5 reset cout", longint'(cout), 0);
    chk(cout_valid == 0, "R5 reset valid", longint'(cout_valid), 0);
    chk(acc_all == '0, "R7 cleared accs", longint'(acc_all[AW-1:0]), 0);
    acc_clr = '0;

    // R3: a single marker coefficient reaches cout after 8*(d+1) shifts
    for (int d = 0; d < 4; d++) begin
      rst_n = 0; dec_sel = 2'(d);
      tick(); tick();
      rst_n = 1;
      tick(); tick();
      coef_en_n = 0; cin = '0;
      tick();
      cin = 9'h0A1 + 9'(d);
      tick();
      cin = '0;
      repeat (8*(d+1) - 2) tick();
      chk(cout == 0, "R3 marker early", longint'(cout), 0);
      tick();
      chk(cout == 9'h0A1 + 9'(d), "R3 marker arrival", longint'(cout), longint'(9'h0A1 + 9'(d)));
      coef_en_n = 1;
    end

    // R2: chain holds while the enable is high, whatever cin does
    tick(); tick();
    held = cout;
    for (int k = 0; k < 10; k++) begin
      cin = 9'($urandom);
      tick();
    end
    chk(cout == held, "R2 hold", longint'(cout), longint'(held));

    // R4 R6 R7: random streaming with decimation changes and clears
    for (int k = 0; k < 600; k++) begin
      if (k % 23 == 0) dec_sel = 2'($urandom);
      data_en_n = ($urandom % 4) == 0;
      coef_en_n = ($urandom % 3) == 0;
      din = 9'($urandom);
      cin = 9'($urandom);
      acc_clr = (($urandom % 8) == 0) ? N'($urandom) : '0;
      tick();
    end

    // R5: reset colliding with a shift leaves the accumulators untouched
    data_en_n = 1; acc_clr = '0;
    repeat (3) tick();
    snap = acc_all;
    coef_en_n = 0; cin = 9'h15A; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick(); tick();
    chk(acc_all == snap, "R5 accs kept", longint'(acc_all[AW-1:0]), longint'(snap[AW-1:0]));
    coef_en_n = 1;
    tick();

    // R9: product 65536 accumulated 512 and 1024 times
    dec_sel = 2'd0; coef_en_n = 0; cin = 9'h100; data_en_n = 0; din = 9'h100;
    repeat (12) tick();
    coef_en_n = 1;
    tick(); tick();
    acc_clr = '1;
    tick();
    acc_clr = '0;
    repeat (512) tick();
    for (int i = 0; i < N; i++)
      chk(acc_all[i*AW +: AW] == 26'h2000000, "R9 half wrap",
          longint'(acc_all[i*AW +: AW]), 64'h2000000);
    repeat (512) tick();
    for (int i = 0; i < N; i++)
      chk(acc_all[i*AW +: AW] == 26'h0, "R9 full wrap",
          longint'(acc_all[i*AW +: AW]), 0);

    // R1: gated input adds nothing
    data_en_n = 1;
    tick(); tick();
    acc_clr = '1;
    tick();
    acc_clr = '0;
    repeat (5) tick();
    for (int i = 0; i < N; i++)
      chk(acc_all[i*AW +: AW] == 26'h0, "R1 gated zero",
          longint'(acc_all[i*AW +: AW]), 0);

    // R1 R6: enabled sample 1 times coefficient -256
    data_en_n = 0; din = 9'h001;
    tick(); tick(); tick();
    chk(acc_all[AW-1:0] == 26'h3FFFF00, "R1 R6 signed product",
        longint'(acc_all[AW-1:0]), 64'h3FFFF00);

    tick();
    finish_run();
  end

endmodule